// File: doc/BRIEF.md
# Asynchronous Character Receiver with Flow-Control Filter

This block recovers start/stop framed characters from a serial receive line. A clock enable at sixteen times the bit rate drives it. It first confirms the start bit at its centre. It then samples each data bit at mid-bit, least significant bit first, and checks the stop bit. The finished character goes into a small first-in first-out store, along with a flag that is set when the stop bit was wrong. A two-bit code sets the character length to 5, 6, 7 or 8 data bits. A shorter character is right-aligned and its upper bits are zero.

A receiver enable switches the block on and off. While the enable is low, the line is ignored. Two programmable byte inputs hold the resume and pause flow-control characters. Each time one of them arrives, a one-cycle indication pulses, whether or not the character is stored. A filter switch selects what happens to those two characters: with the switch low they go into the store like any other character, and with it high they are kept out. If a character that should be stored arrives while the store is full, it is lost and a sticky overrun flag is set.

Top module: `async_char_rx`

## Requirements
- R1: The length code selects the data bits per character: 2'b00 gives 8, 2'b01 gives 7, 2'b10 gives 6 and 2'b11 gives 5. The bits above the selected length read as zero.
- R2: While `rx_active` is low, the line is ignored and nothing is stored.
- R3: If `rx_active` falls while a character is being received, that partial character is discarded. The next complete character after the enable returns is received correctly.
- R4: With `filter_en` low, every character is stored, including characters equal to `xon_char` or `xoff_char`.
- R5: With `filter_en` high, a character equal to `xon_char` or `xoff_char` (compared on the right-aligned, zero-extended value) is not stored.
- R6: A received character equal to `xon_char` raises `xon_seen`, and one equal to `xoff_char` raises `xoff_seen`. Each pulse lasts exactly one clock cycle, whatever the setting of `filter_en`.
- R7: A low on the line that is gone before the centre of the start bit (8 ticks after the falling edge) is ignored.
- R8: Data bits are taken at mid-bit, 16 ticks apart, least significant bit first.
- R9: A low stop bit sets `rd_ferr` for that character, and the character is still stored. A high stop bit leaves `rd_ferr` clear.
- R10: A character that should be stored but finds the store full is dropped and sets `overrun`, which stays high until reset. A character dropped by the filter never sets `overrun`. After reset, `overrun` is low and the store is empty.
- R11: Characters are read in arrival order. `rd_data` and `rd_ferr` show the oldest entry, and `rd_en` removes it. `fifo_empty` and `fifo_full` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial receive line, idle high |
| rx_active | input | 1 | Receiver enable |
| len_code | input | 2 | Character length code |
| filter_en | input | 1 | Keep flow-control characters out of the store |
| xon_char | input | 8 | Resume character value |
| xoff_char | input | 8 | Pause character value |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | 8 | Oldest stored character |
| rd_ferr | output | 1 | Framing error flag of the oldest entry |
| fifo_empty | output | 1 | Store empty |
| fifo_full | output | 1 | Store full |
| overrun | output | 1 | Sticky lost-character flag |
| xon_seen | output | 1 | One-cycle pulse on a resume character |
| xoff_seen | output | 1 | One-cycle pulse on a pause character |

## Verification
Two functions act on the same clock edge: flow-control detection and the store-or-drop decision. Every completed character produces its indication pulse and its write, or its drop, on that one edge. The bench sends the resume and pause values with the filter off and on. For each one it judges the pulse count and the store occupancy together. It then sends a pause character while the store is full and the filter is on. The pulse must still appear, and `overrun` must stay low, because the filter drop happens before the full check.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int MAX_BITS = 8;

    typedef enum logic [1:0] {
        LEN8 = 2'b00,
        LEN7 = 2'b01,
        LEN6 = 2'b10,
        LEN5 = 2'b11
    } len_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic                ferr;
        logic [MAX_BITS-1:0] data;
    } rx_char_t;

    // 00 -> 8, 01 -> 7, 10 -> 6, 11 -> 5
    function automatic logic [3:0] bits_for(len_code_e c);
        return 4'd8 - {2'b00, c};
    endfunction

endpackage

// File: rtl/rx_framer.sv
module rx_framer
    import async_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       rx_active,
    input  logic [1:0] len_code,
    output logic       char_valid,
    output rx_char_t   char_out
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line;
    logic                   prev_q;
    rx_state_e              state_q;
    logic [CW-1:0]          cnt_q;
    logic [3:0]             bit_idx_q;
    logic [3:0]             nbits_q;
    logic [MAX_BITS-1:0]    shreg_q;
    logic [MAX_BITS-1:0]    aligned;

    // Metastability guard on the asynchronous line
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
    assign line = sync_q[SYNC_STAGES-1];

    // Bits arrive LSB first into the top of the shifter; right-align them
    assign aligned = shreg_q >> (4'd8 - nbits_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= 1'b1;
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            bit_idx_q  <= '0;
            nbits_q    <= 4'd8;
            shreg_q    <= '0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            char_valid <= 1'b0;
            if (!rx_active) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
                prev_q  <= line;
            end else if (os_tick) begin
                prev_q <= line;
                case (state_q)
                    ST_IDLE: begin
                        if (prev_q && !line) begin
                            state_q <= ST_START;
                            cnt_q   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == HALF) begin
                            cnt_q <= '0;
                            if (!line) begin
                                state_q   <= ST_DATA;
                                bit_idx_q <= '0;
                                nbits_q   <= bits_for(len_code_e'(len_code));
                                shreg_q   <= '0;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            shreg_q <= {line, shreg_q[MAX_BITS-1:1]};
                            if (bit_idx_q == nbits_q - 4'd1) state_q <= ST_STOP;
                            else bit_idx_q <= bit_idx_q + 4'd1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q         <= '0;
                            state_q       <= ST_IDLE;
                            char_valid    <= 1'b1;
                            char_out.data <= aligned;
                            char_out.ferr <= !line;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/flow_match.sv
module flow_match
    import async_rx_pkg::*;
(
    input  logic                char_valid,
    input  logic [MAX_BITS-1:0] data,
    input  logic [MAX_BITS-1:0] xon_char,
    input  logic [MAX_BITS-1:0] xoff_char,
    input  logic                filter_en,
    output logic                hit_xon,
    output logic                hit_xoff,
    output logic                store
);

    assign hit_xon  = char_valid && (data == xon_char);
    assign hit_xoff = char_valid && (data == xoff_char);
    assign store    = char_valid && !(filter_en && (hit_xon || hit_xoff));

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import async_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  rx_char_t                   wr_data,
    input  logic                       rd_en,
    output rx_char_t                   rd_data,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr_q;
    logic [AW-1:0]   rd_ptr_q;
    logic [NW-1:0]   count_q;
    logic            push;
    logic            pop;

    assign empty   = (count_q == '0);
    assign full    = (count_q == NW'(DEPTH));
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rd_ptr_q];
    assign count   = count_q;

    function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= next_ptr(wr_ptr_q);
            if (pop)  rd_ptr_q <= next_ptr(rd_ptr_q);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
    import async_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FIFO_DEPTH  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       rx_active,
    input  logic [1:0] len_code,
    input  logic       filter_en,
    input  logic [7:0] xon_char,
    input  logic [7:0] xoff_char,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_ferr,
    output logic       fifo_empty,
    output logic       fifo_full,
    output logic       overrun,
    output logic       xon_seen,
    output logic       xoff_seen
);

    localparam int NW = $clog2(FIFO_DEPTH + 1);

    logic            char_valid;
    rx_char_t        char_q;
    logic            hit_xon;
    logic            hit_xoff;
    logic            store;
    rx_char_t        head;
    logic [NW-1:0]   fifo_count;

    rx_framer #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .os_tick    (os_tick),
        .rxd        (rxd),
        .rx_active  (rx_active),
        .len_code   (len_code),
        .char_valid (char_valid),
        .char_out   (char_q)
    );

    flow_match u_match (
        .char_valid (char_valid),
        .data       (char_q.data),
        .xon_char   (xon_char),
        .xoff_char  (xoff_char),
        .filter_en  (filter_en),
        .hit_xon    (hit_xon),
        .hit_xoff   (hit_xoff),
        .store      (store)
    );

    rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store),
        .wr_data (char_q),
        .rd_en   (rd_en),
        .rd_data (head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .count   (fifo_count)
    );

    assign rd_data = head.data;
    assign rd_ferr = head.ferr;

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun   <= 1'b0;
            xon_seen  <= 1'b0;
            xoff_seen <= 1'b0;
        end else begin
            xon_seen  <= hit_xon;
            xoff_seen <= hit_xoff;
            if (store && fifo_full) overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/async_char_rx_chk.sv
module async_char_rx_chk #(
    parameter int NW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_active,
    input logic [1:0]    len_code,
    input logic          filter_en,
    input logic [7:0]    xon_char,
    input logic [7:0]    xoff_char,
    input logic          rd_en,
    input logic          char_valid,
    input logic [7:0]    char_data,
    input logic [NW-1:0] fifo_count,
    input logic          fifo_empty,
    input logic          fifo_full,
    input logic          overrun,
    input logic          xon_seen,
    input logic          xoff_seen
);

    p_len5_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (char_valid && len_code == 2'b11) |-> (char_data[7:5] == 3'b000));

    p_inactive_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !rx_active |=> !char_valid);

    p_filter_holds_count_r5: assert property (@(posedge clk) disable iff (rst)
        (char_valid && filter_en && !rd_en &&
         (char_data == xon_char || char_data == xoff_char))
        |=> (fifo_count == $past(fifo_count)));

    p_xon_single_r6: assert property (@(posedge clk) disable iff (rst)
        xon_seen |=> !xon_seen);

    p_xoff_single_r6: assert property (@(posedge clk) disable iff (rst)
        xoff_seen |=> !xoff_seen);

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    p_empty_full_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(fifo_empty && fifo_full));

endmodule

bind async_char_rx async_char_rx_chk #(.NW($clog2(FIFO_DEPTH + 1))) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_active  (rx_active),
    .len_code   (len_code),
    .filter_en  (filter_en),
    .xon_char   (xon_char),
    .xoff_char  (xoff_char),
    .rd_en      (rd_en),
    .char_valid (char_valid),
    .char_data  (char_q.data),
    .fifo_count (fifo_count),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .overrun    (overrun),
    .xon_seen   (xon_seen),
    .xoff_seen  (xoff_seen)
);

// File: tb/async_char_rx_bench.sv
module async_char_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;
    localparam logic [7:0] XON  = 8'h11;
    localparam logic [7:0] XOFF = 8'h13;

    // {len[1:0], filter, data[7:0], exp_store, exp_data[7:0], exp_xon, exp_xoff}
    localparam int NV = 11;
    localparam logic [21:0] VECS [NV] = '{
        {2'b00, 1'b0, 8'hA5, 1'b1, 8'hA5, 1'b0, 1'b0},
        {2'b01, 1'b0, 8'hFF, 1'b1, 8'h7F, 1'b0, 1'b0},
        {2'b10, 1'b0, 8'hC3, 1'b1, 8'h03, 1'b0, 1'b0},
        {2'b11, 1'b0, 8'hFF, 1'b1, 8'h1F, 1'b0, 1'b0},
        {2'b00, 1'b0, 8'h11, 1'b1, 8'h11, 1'b1, 1'b0},
        {2'b00, 1'b0, 8'h13, 1'b1, 8'h13, 1'b0, 1'b1},
        {2'b00, 1'b1, 8'h11, 1'b0, 8'h00, 1'b1, 1'b0},
        {2'b00, 1'b1, 8'h13, 1'b0, 8'h00, 1'b0, 1'b1},
        {2'b00, 1'b1, 8'h12, 1'b1, 8'h12, 1'b0, 1'b0},
        {2'b11, 1'b1, 8'h11, 1'b0, 8'h00, 1'b1, 1'b0},
        {2'b01, 1'b0, 8'h80, 1'b1, 8'h00, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_active = 1'b1;
    logic [1:0] len_code = 2'b00;
    logic       filter_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ferr;
    logic       fifo_empty;
    logic       fifo_full;
    logic       overrun;
    logic       xon_seen;
    logic       xoff_seen;

    int checks = 0;
    int fails  = 0;
    int xon_cnt  = 0;
    int xoff_cnt = 0;
    int tick_div = 0;

    async_char_rx u_async_char_rx (
        .clk        (clk),
        .rst        (rst),
        .os_tick    (os_tick),
        .rxd        (rxd),
        .rx_active  (rx_active),
        .len_code   (len_code),
        .filter_en  (filter_en),
        .xon_char   (XON),
        .xoff_char  (XOFF),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_ferr    (rd_ferr),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .overrun    (overrun),
        .xon_seen   (xon_seen),
        .xoff_seen  (xoff_seen)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        tick_div <= (tick_div == TICK_DIV - 1) ? 0 : tick_div + 1;
        os_tick  <= (tick_div == TICK_DIV - 1);
        if (xon_seen)  xon_cnt  <= xon_cnt + 1;
        if (xoff_seen) xoff_cnt <= xoff_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] d, input int nb, input logic stop, input int drop_at);
        rxd = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            if (i == drop_at) rx_active = 1'b0;
            rxd = d[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT_CLKS) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);

        // Reset state
        check(fifo_empty == 1'b1, "R10 reset empty", fifo_empty, 1);
        check(fifo_full == 1'b0, "R11 reset not full", fifo_full, 0);
        check(overrun == 1'b0, "R10 reset overrun", overrun, 0);

        // Table walk: R1 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            logic [21:0] e = VECS[v];
            int nb;
            int x0, f0;
            len_code  = e[21:20];
            filter_en = e[19];
            nb = 8 - int'(e[21:20]);
            x0 = xon_cnt;
            f0 = xoff_cnt;
            send_char(e[18:11], nb, 1'b1, -1);
            check(fifo_empty == !e[10], "R4/R5 store decision", fifo_empty, !e[10]);
            if (e[10]) begin
                check(rd_data == e[9:2], "R1 R8 data", rd_data, e[9:2]);
                check(rd_ferr == 1'b0, "R9 good stop", rd_ferr, 0);
                pop();
            end
            check(xon_cnt - x0 == int'(e[1]), "R6 xon pulse", xon_cnt - x0, e[1]);
            check(xoff_cnt - f0 == int'(e[0]), "R6 xoff pulse", xoff_cnt - f0, e[0]);
        end

        len_code  = 2'b00;
        filter_en = 1'b0;

        // R9 framing error
        send_char(8'h5A, 8, 1'b0, -1);
        check(fifo_empty == 1'b0, "R9 stored with bad stop", fifo_empty, 0);
        check(rd_data == 8'h5A, "R9 data", rd_data, 8'h5A);
        check(rd_ferr == 1'b1, "R9 ferr", rd_ferr, 1);
        pop();

        // R7 glitch
        rxd = 1'b0;
        repeat (2 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        check(fifo_empty == 1'b1, "R7 glitch ignored", fifo_empty, 1);

        // R2 receiver inactive
        rx_active = 1'b0;
        send_char(8'h3C, 8, 1'b1, -1);
        check(fifo_empty == 1'b1, "R2 inactive", fifo_empty, 1);
        rx_active = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R3 drop mid-character, then recover
        send_char(8'hE7, 8, 1'b1, 3);
        check(fifo_empty == 1'b1, "R3 partial discarded", fifo_empty, 1);
        rx_active = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        send_char(8'h4B, 8, 1'b1, -1);
        check(rd_data == 8'h4B && !fifo_empty, "R3 recovery", rd_data, 8'h4B);
        pop();

        // R10 overrun, R11 ordering
        for (int i = 0; i < 8; i++) send_char(8'h20 + 8'(i), 8, 1'b1, -1);
        check(fifo_full == 1'b1, "R11 full", fifo_full, 1);
        begin
            int f0 = xoff_cnt;
            filter_en = 1'b1;
            send_char(XOFF, 8, 1'b1, -1);
            check(overrun == 1'b0, "R10 filtered no overrun", overrun, 0);
            check(xoff_cnt - f0 == 1, "R6 pulse while full", xoff_cnt - f0, 1);
            filter_en = 1'b0;
        end
        send_char(8'h77, 8, 1'b1, -1);
        check(overrun == 1'b1, "R10 overrun set", overrun, 1);
        for (int i = 0; i < 8; i++) begin
            check(rd_data == 8'h20 + 8'(i), "R11 order", rd_data, 8'h20 + i);
            pop();
        end
        check(fifo_empty == 1'b1, "R10 dropped char absent", fifo_empty, 1);
        check(overrun == 1'b1, "R10 sticky", overrun, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule